// File: doc/BRIEF.md
# Jump Target Generator for Vectors, Table Calls and Page Calls

This block produces the 16-bit program address that a small 8-bit processor jumps to when it leaves normal sequential flow: at reset, on an accepted hardware interrupt, on a software break, on a one-byte table call and on a two-byte page call. For the vectored kinds it works out where the two-byte vector sits in the top of program memory. It then reads the low byte and the high byte over two consecutive cycles, joins them into a target and presents that target for one cycle with a valid strobe. A page call needs no memory access. Its one-byte operand selects an address inside the highest 256-byte page, and the target is ready on the next cycle.

The sequencer takes a request kind, a 4-bit index that names the interrupt source or the table entry, and an operand byte. The block drops any request that arrives while a fetch is running. Interrupt source numbers that have no vector, and request kinds that are not defined, are refused with a one-cycle reject strobe. Priority between interrupts and the saving of return state belong to other blocks.

Top module: `vec_target_gen`

## Requirements
- R1: After reset is released, `tgt_valid`, `req_reject`, `mem_rd` and `busy` are all low until a request is accepted.
- R2: A reset request (`req_kind` = 0) fetches its target from location 0xFFFE (low byte) and 0xFFFF (high byte).
- R3: An interrupt request (`req_kind` = 1) with index i from 0 to 7 fetches from location 0xFFFA − 2·i. The sources map as follows: 0 external 0 (0xFFFA), 1 external 1 (0xFFF8), 2 watchdog (0xFFF6), 3 timer 0 (0xFFF4), 4 timer 1 (0xFFF2), 5 converter (0xFFF0), 6 interval timer (0xFFEE), 7 serial (0xFFEC).
- R4: An interrupt request with index 8 to 15 is refused: `req_reject` pulses high for one cycle, one cycle after acceptance, with no memory read and no `tgt_valid`.
- R5: A table call (`req_kind` = 3) with entry n from 0 to 15 fetches from location 0xFFDE − 2·n, so entry 15 is at 0xFFC0 and entry 0 is at 0xFFDE.
- R6: A software break (`req_kind` = 2) fetches from 0xFFDE, the same location as table entry 0, whatever the index.
- R7: A page call (`req_kind` = 4) gives target {0xFF, operand} with `tgt_valid` high in the cycle after acceptance, and performs no memory read.
- R8: A vector fetch drives `mem_rd` for exactly two consecutive cycles. The first cycle starts in the cycle after acceptance and carries the vector location. The second carries that location plus one. `mem_rdata` returns the byte of a read in the cycle after the read.
- R9: The target of a vector fetch is {byte read second, byte read first}. `tgt_valid` is high for exactly one cycle, three cycles after the first read cycle.
- R10: Request kinds 5, 6 and 7 are refused in the same way as in R4.
- R11: While `busy` is high, `req_valid` is ignored. A request held during a fetch neither changes that fetch's target nor produces an extra strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, accepted when `busy` is low |
| req_kind | input | 3 | 0 reset, 1 interrupt, 2 break, 3 table call, 4 page call |
| req_index | input | 4 | Interrupt source or table entry number |
| req_operand | input | 8 | Page-call operand byte |
| busy | output | 1 | A vector fetch is in progress |
| mem_rd | output | 1 | Program memory read strobe |
| mem_addr | output | 16 | Program memory read address |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| tgt_valid | output | 1 | One-cycle strobe qualifying `tgt_addr` |
| tgt_addr | output | 16 | Jump target |
| req_reject | output | 1 | One-cycle strobe for a refused request |

## Verification
Counting from the clock edge that accepts a request, the first read is due in the cycle that follows it and the second read in the cycle after that. A vector target is due in the fourth cycle, while a page target or a reject strobe is due in the first. The bench drives each request before a rising edge. It then walks forward one falling edge per cycle and checks each of these outputs at exactly its cycle. It also confirms that the strobes are low in the cycles on either side of the one where they are due. A request held through a running fetch is checked at the fourth cycle and at the cycle after it, so that a wrong target or a stray strobe caused by the held request is visible.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [2:0] {
    K_RESET = 3'd0,
    K_IRQ   = 3'd1,
    K_BREAK = 3'd2,
    K_TABLE = 3'd3,
    K_PAGE  = 3'd4
  } req_kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RD_LO = 2'd1,
    S_RD_HI = 2'd2,
    S_CAP   = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/vtg_vec_addr.sv
module vtg_vec_addr #(
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 4,
  parameter int KIND_W    = 3,
  parameter int IRQ_COUNT = 8,
  parameter logic [ADDR_W-1:0] RESET_LOC = 16'hFFFE,
  parameter logic [ADDR_W-1:0] IRQ_TOP   = 16'hFFFA,
  parameter logic [ADDR_W-1:0] TABLE_TOP = 16'hFFDE
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] loc,
  output logic              is_vec,
  output logic              is_page,
  output logic              is_bad
);
  import vtg_pkg::*;

  localparam int PAD_W = ADDR_W - IDX_W - 1;

  logic [ADDR_W-1:0] idx_x2;
  logic              irq_known;

  assign idx_x2    = {{PAD_W{1'b0}}, index, 1'b0};
  assign irq_known = (32'(index) < IRQ_COUNT);

  always_comb begin
    loc     = RESET_LOC;
    is_vec  = 1'b0;
    is_page = 1'b0;
    is_bad  = 1'b0;
    case (req_kind_e'(kind))
      K_RESET: begin
        loc    = RESET_LOC;
        is_vec = 1'b1;
      end
      K_IRQ: begin
        loc    = IRQ_TOP - idx_x2;
        is_vec = irq_known;
        is_bad = !irq_known;
      end
      K_BREAK: begin
        loc    = TABLE_TOP;
        is_vec = 1'b1;
      end
      K_TABLE: begin
        loc    = TABLE_TOP - idx_x2;
        is_vec = 1'b1;
      end
      K_PAGE: begin
        is_page = 1'b1;
      end
      default: begin
        is_bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/vtg_fetch_fsm.sv
module vtg_fetch_fsm #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_vec,
  input  logic [ADDR_W-1:0] base_loc,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cap_lo,
  output logic              cap_hi
);
  import vtg_pkg::*;

  fetch_state_e      state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start_vec) begin
          state_d = S_RD_LO;
          addr_d  = base_loc;
          addr_en = 1'b1;
        end
      end
      S_RD_LO: begin
        state_d = S_RD_HI;
        addr_d  = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
        addr_en = 1'b1;
      end
      S_RD_HI: state_d = S_CAP;
      S_CAP:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign busy     = (state_q != S_IDLE);
  assign mem_rd   = (state_q == S_RD_LO) || (state_q == S_RD_HI);
  assign mem_addr = addr_q;
  assign cap_lo   = (state_q == S_RD_HI);
  assign cap_hi   = (state_q == S_CAP);
endmodule

// File: rtl/vtg_assemble.sv
module vtg_assemble #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] PAGE_HI = 8'hFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_lo,
  input  logic                cap_hi,
  input  logic                page_load,
  input  logic                bad_load,
  input  logic [DATA_W-1:0]   operand,
  input  logic [DATA_W-1:0]   rdata,
  output logic [2*DATA_W-1:0] tgt_addr,
  output logic                tgt_valid,
  output logic                reject
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [DATA_W-1:0] lo_q;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic              tgt_en;
  logic              valid_q, valid_d;
  logic              rej_q, rej_d;

  always_comb begin
    tgt_d   = tgt_q;
    tgt_en  = 1'b0;
    valid_d = cap_hi | page_load;
    rej_d   = bad_load;
    if (cap_hi) begin
      tgt_d  = {rdata, lo_q};
      tgt_en = 1'b1;
    end else if (page_load) begin
      tgt_d  = {PAGE_HI, operand};
      tgt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      tgt_q   <= '0;
      valid_q <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      if (cap_lo) lo_q <= rdata;
      if (tgt_en) tgt_q <= tgt_d;
      valid_q <= valid_d;
      rej_q   <= rej_d;
    end
  end

  assign tgt_addr  = tgt_q;
  assign tgt_valid = valid_q;
  assign reject    = rej_q;
endmodule

// File: rtl/vec_target_gen.sv
module vec_target_gen #(
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 4,
  parameter int KIND_W    = 3,
  parameter int IRQ_COUNT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [KIND_W-1:0]   req_kind,
  input  logic [IDX_W-1:0]    req_index,
  input  logic [DATA_W-1:0]   req_operand,
  output logic                busy,
  output logic                mem_rd,
  output logic [2*DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                tgt_valid,
  output logic [2*DATA_W-1:0] tgt_addr,
  output logic                req_reject
);
  localparam int ADDR_W = 2 * DATA_W;

  logic              rst_meta_n, rst_sync_n;
  logic [ADDR_W-1:0] loc;
  logic              is_vec, is_page, is_bad;
  logic              accept;
  logic              cap_lo, cap_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  vtg_vec_addr #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .KIND_W(KIND_W), .IRQ_COUNT(IRQ_COUNT)
  ) u_loc (
    .kind(req_kind), .index(req_index), .loc(loc),
    .is_vec(is_vec), .is_page(is_page), .is_bad(is_bad)
  );

  assign accept = req_valid && !busy;

  vtg_fetch_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .start_vec(accept && is_vec),
    .base_loc(loc), .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .cap_lo(cap_lo), .cap_hi(cap_hi)
  );

  vtg_assemble #(.DATA_W(DATA_W)) u_asm (
    .clk(clk), .rst_n(rst_sync_n), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .page_load(accept && is_page), .bad_load(accept && is_bad),
    .operand(req_operand), .rdata(mem_rdata),
    .tgt_addr(tgt_addr), .tgt_valid(tgt_valid), .reject(req_reject)
  );
endmodule

// File: rtl/vec_target_gen_chk.sv
module vec_target_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  req_kind,
  input logic        busy,
  input logic        mem_rd,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_rdata,
  input logic        tgt_valid,
  input logic [15:0] tgt_addr,
  input logic        req_reject
);
  p_second_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |=> mem_rd && (mem_addr == $past(mem_addr) + 16'd1));

  p_two_reads_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |=> !mem_rd);

  p_join_bytes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid && $past(mem_rd, 2) && !$past(mem_rd)
      |-> tgt_addr == {$past(mem_rdata), $past(mem_rdata, 2)});

  p_page_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !busy && req_kind == 3'd4)
      |-> tgt_valid && !mem_rd && tgt_addr[15:8] == 8'hFF);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tgt_valid && req_reject));

  p_read_in_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);
endmodule

bind vec_target_gen vec_target_gen_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_kind(req_kind),
  .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
  .tgt_valid(tgt_valid), .tgt_addr(tgt_addr), .req_reject(req_reject)
);

// File: tb/vec_target_gen_test.sv
`timescale 1ns/1ps
module vec_target_gen_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [3:0]  req_index;
  logic [7:0]  req_operand;
  logic        busy, mem_rd, tgt_valid, req_reject;
  logic [15:0] mem_addr, tgt_addr;
  logic [7:0]  mem_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vec_target_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_index(req_index), .req_operand(req_operand), .busy(busy),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .tgt_valid(tgt_valid), .tgt_addr(tgt_addr), .req_reject(req_reject)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  always @(posedge clk) mem_rdata <= mem_byte(mem_addr);

  // class: 0 vector fetch, 1 page call, 2 refused
  function automatic int req_class(input logic [2:0] k, input logic [3:0] i);
    if (k == 3'd4) return 1;
    if (k > 3'd4) return 2;
    if (k == 3'd1 && i > 4'd7) return 2;
    return 0;
  endfunction

  function automatic logic [15:0] req_loc(input logic [2:0] k, input logic [3:0] i);
    case (k)
      3'd0: return 16'hFFFE;
      3'd1: return 16'hFFFA - 16'(2 * int'(i));
      3'd2: return 16'hFFDE;
      default: return 16'hFFDE - 16'(2 * int'(i));
    endcase
  endfunction

  function automatic string req_tag(input logic [2:0] k, input logic [3:0] i);
    if (k > 3'd4) return "R10";
    case (k)
      3'd0: return "R2";
      3'd1: return (i > 4'd7) ? "R4" : "R3";
      3'd2: return "R6";
      3'd3: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] k, input logic [3:0] i, input logic [7:0] op);
    logic [15:0] loc;
    string tag;
    int cls;
    loc = req_loc(k, i);
    tag = req_tag(k, i);
    cls = req_class(k, i);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_index = i; req_operand = op;
    @(negedge clk);                  // cycle 1 after acceptance
    req_valid = 1'b0;
    if (cls == 0) begin
      check(mem_rd && mem_addr == loc, tag, mem_addr, loc);           // first read, R8
      @(negedge clk);
      check(mem_rd && mem_addr == loc + 16'd1, "R8", mem_addr, loc + 16'd1);
      @(negedge clk);
      check(!mem_rd && !tgt_valid, "R8", {14'd0, mem_rd, tgt_valid}, 16'd0);
      @(negedge clk);
      check(tgt_valid && tgt_addr == {mem_byte(loc + 16'd1), mem_byte(loc)}, "R9",
            tgt_addr, {mem_byte(loc + 16'd1), mem_byte(loc)});
      @(negedge clk);
      check(!tgt_valid, "R9", {15'd0, tgt_valid}, 16'd0);
    end else if (cls == 1) begin
      check(tgt_valid && !mem_rd && !busy && tgt_addr == {8'hFF, op}, "R7",
            tgt_addr, {8'hFF, op});
    end else begin
      check(req_reject && !tgt_valid && !mem_rd && !busy, tag,
            {13'd0, req_reject, tgt_valid, mem_rd}, 16'h0004);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 16'd0, 16'd1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_index = '0; req_operand = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!tgt_valid && !req_reject && !mem_rd && !busy, "R1",
          {12'd0, tgt_valid, req_reject, mem_rd, busy}, 16'd0);

    // directed corners
    run_req(3'd0, 4'd9, 8'h00);                        // R2 reset vector
    for (int s = 0; s < 8; s++) run_req(3'd1, 4'(s), 8'h00);  // R3 all sources
    run_req(3'd1, 4'd8, 8'h00);                        // R4 first undefined
    run_req(3'd1, 4'd15, 8'h00);                       // R4 last undefined
    run_req(3'd3, 4'd0, 8'h00);                        // R5 entry 0
    run_req(3'd3, 4'd15, 8'h00);                       // R5 entry 15 at 0xFFC0
    run_req(3'd2, 4'd7, 8'h00);                        // R6 break, index ignored
    run_req(3'd4, 4'd0, 8'h00);                        // R7 lowest page target
    run_req(3'd4, 4'd3, 8'hFF);                        // R7 highest page target
    for (int k = 5; k < 8; k++) run_req(3'(k), 4'd0, 8'h00);  // R10

    // R11: hold a page request during a fetch of source 0
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd1; req_index = 4'd0; req_operand = 8'h00;
    @(negedge clk);
    req_kind = 3'd4; req_operand = 8'h33;
    @(negedge clk);
    @(negedge clk);
    check(!tgt_valid, "R11", {15'd0, tgt_valid}, 16'd0);
    @(negedge clk);
    req_valid = 1'b0;
    check(tgt_valid && tgt_addr == {mem_byte(16'hFFFB), mem_byte(16'hFFFA)}, "R11",
          tgt_addr, {mem_byte(16'hFFFB), mem_byte(16'hFFFA)});
    @(negedge clk);
    check(!tgt_valid && !req_reject, "R11", {14'd0, tgt_valid, req_reject}, 16'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      run_req(3'($urandom_range(0, 7)), 4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)));
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule